// File: doc/BRIEF.md
# Sticky Interrupt Collector

This block gathers a word of level-sensitive interrupt request lines into a sticky status register behind a small 32-bit register bus. Every clock cycle, each request line that is high and enabled in the mask register sets its status bit. That bit then holds after the line drops, until software clears it by writing a one to it. A single registered interrupt output is high while any status bit is set. Because the status word is re-evaluated every cycle, a write to the mask register or a clear of the status register takes effect within one cycle.

The bank also stores two routing words and a polarity word. Software can write and read them back, but they drive no logic. The sampled request lines are visible in a read-only register. Bus accesses are whole 32-bit words with bit 31 as the most significant bit. Registers are selected by word offset, and address bits 1:0 are ignored. Read data is registered and appears one cycle after the read request.

Top module: `sticky_irq_collector`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq_out` is low.
- R2: The words at byte offsets 0x08, 0x0C, 0x54 (mask) and 0x58 (polarity) read back the last value written. Read data is valid on `bus_rdata` in the cycle after the read request.
- R3: The register at offset 0x5C returns the request lines as they were sampled one clock earlier, bit n holding `irq_in[n]`. For example, a line on bit 11 reads as 0x00000800.
- R4: A sampled request bit that is high while its mask bit is one sets the matching status bit (offset 0x50) on the next clock.
- R5: A status bit stays set after its request line falls, and after its mask bit is cleared.
- R6: Writing the status register clears each bit written as one and leaves bits written as zero unchanged. A bit whose sampled request is still high and unmasked is set again in the same cycle, so it stays set.
- R7: `irq_out` is high in exactly those cycles in which the status register is nonzero.
- R8: The polarity register has no effect on status or `irq_out`.
- R9: Writes to the offset 0x5C register are ignored.
- R10: A read of any unimplemented word offset returns 0xFFFFFFFF. A write to one changes no register.
- R11: A request line whose mask bit is zero never sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, one cycle after the read |
| irq_in | input | DW | Level interrupt request lines |
| irq_out | output | 1 | High while any status bit is set |

## Verification
The bench targets four corner cases.

- **Clearing a bit whose line is still active and unmasked.** A design that let the clear win would briefly drop `irq_out` and lose the interrupt.
- **Status after the line falls or the mask is cleared.** A level-following or mask-gated status would lose events.
- **Writes to the polarity and raw-input offsets.** A design that decoded either into logic would corrupt status or the raw view.
- **Unmapped offsets.** A loose decoder would alias these onto a real register, returning its contents or overwriting it.

Random traffic then mixes clears that collide with new requests and mask changes with reads of every offset.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // Configuration slots held in the generic store
  localparam int CFG_N       = 4;
  localparam int CFG_ROUTE_A = 0;
  localparam int CFG_ROUTE_B = 1;
  localparam int CFG_MASK    = 2;
  localparam int CFG_POL     = 3;
  localparam int CFG_IX_W    = $clog2(CFG_N);

  // Word offsets (byte offset / 4)
  localparam int WIX_ROUTE_A = 'h02;
  localparam int WIX_ROUTE_B = 'h03;
  localparam int WIX_STATUS  = 'h14;
  localparam int WIX_MASK    = 'h15;
  localparam int WIX_POL     = 'h16;
  localparam int WIX_RAW     = 'h17;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_CFG,
    RS_STATUS,
    RS_RAW
  } sic_rsel_t;
endpackage

// File: rtl/sic_decode.sv
module sic_decode
  import sic_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic                rd_en,
  output sic_rsel_t           rsel,
  output logic [CFG_IX_W-1:0] cfg_ix,
  output logic [CFG_N-1:0]    cfg_we,
  output logic                stat_we
);
  localparam int IX_W = ADDR_W - 2;

  logic [IX_W-1:0] wix;
  logic            hit_cfg;

  always_comb begin
    wix     = bus_addr[ADDR_W-1:2];
    rsel    = RS_NONE;
    cfg_ix  = '0;
    hit_cfg = 1'b0;
    case (int'(wix))
      WIX_ROUTE_A: begin rsel = RS_CFG; cfg_ix = CFG_IX_W'(CFG_ROUTE_A); hit_cfg = 1'b1; end
      WIX_ROUTE_B: begin rsel = RS_CFG; cfg_ix = CFG_IX_W'(CFG_ROUTE_B); hit_cfg = 1'b1; end
      WIX_MASK:    begin rsel = RS_CFG; cfg_ix = CFG_IX_W'(CFG_MASK);    hit_cfg = 1'b1; end
      WIX_POL:     begin rsel = RS_CFG; cfg_ix = CFG_IX_W'(CFG_POL);     hit_cfg = 1'b1; end
      WIX_STATUS:  rsel = RS_STATUS;
      WIX_RAW:     rsel = RS_RAW;
      default:     rsel = RS_NONE;
    endcase
    rd_en   = bus_sel && !bus_wr;
    stat_we = bus_sel && bus_wr && (rsel == RS_STATUS);
    cfg_we  = '0;
    if (bus_sel && bus_wr && hit_cfg) cfg_we[cfg_ix] = 1'b1;
  end
endmodule

// File: rtl/sic_cfg.sv
module sic_cfg
  import sic_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CFG_N-1:0]          we,
  input  logic [DW-1:0]             wdata,
  output logic [CFG_N-1:0][DW-1:0]  cfg_q
);
  for (genvar g = 0; g < CFG_N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)        cfg_q[g] <= '0;
      else if (we[g]) cfg_q[g] <= wdata;
    end

    // R2: a slot changes only when written
    a_r2_slot_holds: assert property (@(posedge clk) disable iff (rst)
      !we[g] |=> $stable(cfg_q[g]));
  end
endmodule

// File: rtl/sic_latch.sv
module sic_latch #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] irq_in,
  input  logic [DW-1:0] mask,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_bits,
  output logic [DW-1:0] raw_q,
  output logic [DW-1:0] st_q,
  output logic          irq_q
);
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] st_d;

  always_comb begin
    clr_vec = clr_en ? clr_bits : '0;
    // new requests are ORed after the clear, so an active line wins
    st_d    = (st_q & ~clr_vec) | (raw_q & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= irq_in;
      st_q  <= st_d;
      irq_q <= |st_d;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (st_q == '0 && !irq_q));

  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(st_q) & ~$past(clr_vec)) & ~st_q) == '0));

  a_r4_masked_sets: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(raw_q) & $past(mask)) & ~st_q) == '0));

  a_r11_unmasked_only: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((st_q & ~$past(st_q)) & ~($past(raw_q) & $past(mask))) == '0));

  a_r7_irq_tracks_status: assert property (@(posedge clk) disable iff (rst)
    irq_q == (st_q != '0));
endmodule

// File: rtl/sticky_irq_collector.sv
module sticky_irq_collector
  import sic_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     irq_in,
  output logic              irq_out
);
  logic                     rd_en;
  sic_rsel_t                rsel;
  logic [CFG_IX_W-1:0]      cfg_ix;
  logic [CFG_N-1:0]         cfg_we;
  logic                     stat_we;
  logic [CFG_N-1:0][DW-1:0] cfg_q;
  logic [DW-1:0]            raw_q;
  logic [DW-1:0]            st_q;
  logic [DW-1:0]            rd_mux;
  logic [DW-1:0]            rdata_q;

  sic_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .rd_en   (rd_en),
    .rsel    (rsel),
    .cfg_ix  (cfg_ix),
    .cfg_we  (cfg_we),
    .stat_we (stat_we)
  );

  sic_cfg #(.DW(DW)) u_cfg (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .wdata(bus_wdata),
    .cfg_q(cfg_q)
  );

  sic_latch #(.DW(DW)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .mask    (cfg_q[CFG_MASK]),
    .clr_en  (stat_we),
    .clr_bits(bus_wdata),
    .raw_q   (raw_q),
    .st_q    (st_q),
    .irq_q   (irq_out)
  );

  always_comb begin
    case (rsel)
      RS_CFG:    rd_mux = cfg_q[cfg_ix];
      RS_STATUS: rd_mux = st_q;
      RS_RAW:    rd_mux = raw_q;
      default:   rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  // R10: unmapped reads return all ones on the port
  a_r10_unmapped_ones: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rsel == RS_NONE) |=> (bus_rdata == '1));

  // R9: the raw view follows the request lines, whatever is written
  a_r9_raw_follows_lines: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (raw_q == $past(irq_in)));
endmodule

// File: tb/sim_sticky_irq_collector.sv
module sim_sticky_irq_collector;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] irqv = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  always #10 clk = ~clk;

  sticky_irq_collector #(.DW(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_in(irqv), .irq_out(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] m_r0, m_r1, m_mask, m_pol, m_raw, m_st;

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    case (a[7:2])
      6'h02:   return m_r0;
      6'h03:   return m_r1;
      6'h14:   return m_st;
      6'h15:   return m_mask;
      6'h16:   return m_pol;
      6'h17:   return m_raw;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a[7:2])
      6'h02, 6'h03, 6'h15, 6'h16: return "R2";
      6'h17:   return "R3";
      6'h14:   return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // One bus cycle; starts and ends at a falling edge
  task automatic step(input bit s, input bit w, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] iv, input string req);
    logic [31:0] clr, nst, exp_rd;
    bit rd;
    sel = s; wr = w; addr = a; wdata = d; irqv = iv;
    rd     = s && !w;
    exp_rd = model_rd(a);
    clr    = (s && w && a[7:2] == 6'h14) ? d : 32'h0;
    nst    = (m_st & ~clr) | (m_raw & m_mask);
    @(posedge clk);
    m_st  = nst;
    m_raw = iv;
    if (s && w) begin
      case (a[7:2])
        6'h02: m_r0 = d;
        6'h03: m_r1 = d;
        6'h15: m_mask = d;
        6'h16: m_pol = d;
        default: ;
      endcase
    end
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    chk("R7", {31'b0, irq}, {31'b0, m_st != 0});
    if (rd) chk((req == "") ? tag_of(a) : req, rdata, exp_rd);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [6];
    logic [31:0] cur;
    offs[0] = 8'h08; offs[1] = 8'h0C; offs[2] = 8'h50;
    offs[3] = 8'h54; offs[4] = 8'h58; offs[5] = 8'h5C;
    m_r0 = 0; m_r1 = 0; m_mask = 0; m_pol = 0; m_raw = 0; m_st = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", {31'b0, irq}, 32'h0);
    foreach (offs[i]) step(1, 0, offs[i], 0, 0, "R1");

    // R2: read-back of stored words
    step(1, 1, 8'h08, 32'hA5A5_0001, 0, "");
    step(1, 1, 8'h0C, 32'h5A5A_0002, 0, "");
    step(1, 1, 8'h58, 32'h1234_5678, 0, "");
    step(1, 0, 8'h08, 0, 0, "R2");
    step(1, 0, 8'h0C, 0, 0, "R2");
    step(1, 0, 8'h58, 0, 0, "R2");

    // R11: masked line never sets status; R3: raw view of bit 11
    step(0, 0, 0, 0, 32'h800, "");
    step(0, 0, 0, 0, 32'h800, "");
    step(1, 0, 8'h50, 0, 32'h800, "R11");
    step(1, 0, 8'h5C, 0, 32'h800, "R3");
    chk("R3", m_raw, 32'h0000_0800);

    // R4: unmasking sets status
    step(1, 1, 8'h54, 32'h800, 32'h800, "");
    step(0, 0, 0, 0, 32'h800, "");
    step(1, 0, 8'h50, 0, 32'h800, "R4");
    chk("R4", m_st, 32'h800);

    // R5: sticky after line drop and after mask cleared
    step(0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, "");
    step(1, 0, 8'h50, 0, 0, "R5");
    step(1, 1, 8'h54, 0, 0, "");
    step(1, 0, 8'h50, 0, 0, "R5");

    // R6: zeros leave bits, ones on an active line do not clear
    step(1, 1, 8'h50, 32'h0, 0, "");
    step(1, 0, 8'h50, 0, 0, "R6");
    step(1, 1, 8'h54, 32'h800, 32'h800, "");
    step(0, 0, 0, 0, 32'h800, "");
    step(1, 1, 8'h50, 32'h800, 32'h800, "");
    step(1, 0, 8'h50, 0, 32'h800, "R6");
    step(0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, "");
    step(1, 1, 8'h50, 32'h800, 0, "");
    step(1, 0, 8'h50, 0, 0, "R6");
    chk("R6", m_st, 32'h0);

    // R8: polarity has no effect
    step(1, 1, 8'h54, 32'h3, 0, "");
    step(1, 1, 8'h58, 32'hFFFF_FFFF, 32'h3, "");
    step(0, 0, 0, 0, 32'h1, "");
    step(1, 0, 8'h50, 0, 0, "R8");
    chk("R8", m_st, 32'h3);

    // R9: raw register ignores writes
    step(1, 1, 8'h5C, 32'hDEAD_BEEF, 32'h40, "");
    step(1, 0, 8'h5C, 0, 32'h40, "R9");

    // R10: unmapped offsets
    step(1, 0, 8'h10, 0, 0, "R10");
    step(1, 0, 8'h60, 0, 0, "R10");
    step(1, 0, 8'hFC, 0, 0, "R10");
    step(1, 1, 8'h40, 32'hFFFF_FFFF, 0, "");
    step(1, 1, 8'h04, 32'hFFFF_FFFF, 0, "");
    foreach (offs[i]) step(1, 0, offs[i], 0, 0, "R10");

    // Random mix
    cur = $urandom(32'd2024);
    cur = 0;
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      logic [31:0] d;
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 9) a = 8'($urandom);
      else a = offs[$urandom_range(0, 5)];
      d = (a == 8'h50) ? ($urandom & $urandom) : $urandom;
      if ($urandom_range(0, 3) == 0) cur = $urandom & $urandom & $urandom;
      step(op != 0, $urandom_range(0, 2) == 0, a, d, cur, "");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule